// File: doc/BRIEF.md
# Stream-to-memory packet writer

This block drains a valid/ready byte stream into consecutive words of memory through a single-beat memory-mapped write port. Software, or an upstream scheduler, hands it one descriptor at a time. A descriptor holds a destination byte address, a byte limit and a few flags: end the transfer at end-of-packet, enable the completion interrupt, enable the early-termination interrupt, and an error mask. Beats arrive with an end-of-packet marker, an empty-byte count that is valid on the end-of-packet beat, and an error vector.

Each transfer ends in one of three ways. The byte limit can be reached. End-of-packet can arrive while packet mode is enabled. The limit can cut a packet short, in which case the block swallows the rest of that packet without stalling the source. When the last write has been handed off, the block emits a one-cycle done pulse. The pulse carries the number of bytes actually written, together with the interrupt pulses that the descriptor's masks allow. The stream data lanes are little-endian: lane i holds byte i of the word.

Top module: `pkt_stream_writer`

## Requirements
- R1: While reset is held, desc_ready is 1, and s_ready, m_wvalid, done_valid, irq_done, irq_early and irq_err are all 0.
- R2: A descriptor is taken only while desc_ready is high. desc_ready stays low from acceptance until the done pulse. Accepting a descriptor clears the byte count and the accumulated error bits, so nothing carries over from the previous transfer.
- R3: Each accepted beat that contributes at least one byte produces exactly one write. The k-th write of a transfer (k from 0) goes to byte address desc_addr + k*(DATA_W/8) and carries the beat data with byte i on lane i. A write that is not accepted holds its address, data and enables until m_wready.
- R4: m_wbe is a contiguous run of ones starting at lane 0. A beat without end-of-packet counts DATA_W/8 bytes. A beat with end-of-packet counts DATA_W/8 minus s_empty bytes. The enables are further clipped to the bytes remaining under the limit.
- R5: No transfer writes more than desc_len bytes. With the packet flag clear, end-of-packet does not end the transfer, and the transfer ends on the beat that brings the count to exactly desc_len.
- R6: With the packet flag set, an end-of-packet beat whose bytes fit within the remaining limit ends the transfer normally (no early termination), even when it fills the limit exactly.
- R7: With the packet flag set, reaching the limit before the end-of-packet beat, or an end-of-packet beat larger than what remains, marks early termination. The rest of the packet, up to and including its end-of-packet beat, is accepted with s_ready high and is not written.
- R8: A desc_len of all ones removes the byte limit.
- R9: Error bits on every accepted beat of the transfer, discarded beats included, are OR-accumulated. irq_err pulses at completion exactly when the accumulated bits ANDed with desc_err_mask are nonzero.
- R10: Completion gives one-cycle pulses on done_valid and done_bytes (bytes written). irq_done pulses alongside it when enabled. irq_early pulses alongside it when enabled and early termination occurred. No pulse occurs before the last write has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Destination byte address (word aligned) |
| desc_len | input | LEN_W | Byte limit; all ones means no limit |
| desc_end_on_eop | input | 1 | End the transfer at end-of-packet |
| desc_done_ie | input | 1 | Completion interrupt enable |
| desc_early_ie | input | 1 | Early-termination interrupt enable |
| desc_err_mask | input | ERR_W | Error interrupt mask |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted when valid |
| s_data | input | DATA_W | Stream data, byte i on lane i |
| s_eop | input | 1 | Last beat of packet |
| s_empty | input | EMPTY_W | Unused upper bytes on the end-of-packet beat |
| s_err | input | ERR_W | Error bits of the beat |
| m_wvalid | output | 1 | Write request |
| m_wready | input | 1 | Write accepted |
| m_waddr | output | ADDR_W | Write byte address |
| m_wdata | output | DATA_W | Write data |
| m_wbe | output | DATA_W/8 | Write byte enables |
| done_valid | output | 1 | Transfer finished (one cycle) |
| done_bytes | output | LEN_W | Bytes written by the finished transfer |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_early | output | 1 | Early-termination interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The hardest state to reach is the discard phase while the write port is back-pressured. In that phase a packet has overrun the limit, the final clipped write may still be waiting for m_wready, and further beats carrying error bits must keep flowing without being written. The stimulus builds whole packets before each descriptor, from a reference model that predicts exactly which beats are consumed. It then pairs limits that land mid-packet, on a partial end-of-packet beat, and exactly on the packet end with randomly withheld m_wready. This exercises the discard path under back-pressure, and the bench checks that every discarded beat is taken on first offer.

// File: rtl/pkt_writer_pkg.sv
package pkt_writer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_FIN
  } wr_state_e;
endpackage

// File: rtl/pkt_lane_calc.sv
// Per-beat byte accounting: bytes carried, bytes kept under the limit,
// lane enables and limit flags.
module pkt_lane_calc #(
  parameter int NB      = 4,
  parameter int LEN_W   = 32,
  parameter int EMPTY_W = 2,
  parameter int CNT_W   = 3
) (
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [LEN_W-1:0]   remaining,
  input  logic               unlimited,
  output logic [CNT_W-1:0]   take,
  output logic [NB-1:0]      be,
  output logic               cap_hit,
  output logic               over
);
  logic [CNT_W-1:0] beat_bytes;
  logic [LEN_W-1:0] beat_wide;

  always_comb begin
    beat_bytes = CNT_W'(NB);
    if (eop) beat_bytes = CNT_W'(NB) - CNT_W'(empty);
    beat_wide = LEN_W'(beat_bytes);
    if (unlimited) begin
      take    = beat_bytes;
      over    = 1'b0;
      cap_hit = 1'b0;
    end else begin
      over    = beat_wide > remaining;
      take    = over ? remaining[CNT_W-1:0] : beat_bytes;
      cap_hit = (LEN_W'(take) == remaining);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign be[g] = (CNT_W'(g) < take);
  end
endmodule

// File: rtl/pkt_err_accum.sv
// Sticky OR of error bits over one transfer.
module pkt_err_accum #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic [ERR_W-1:0] err_in,
  output logic [ERR_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (en)      acc <= acc | err_in;
  end
endmodule

// File: rtl/pkt_wr_stage.sv
// Single registered write slot toward the memory port.
module pkt_wr_stage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [NB-1:0]     be,
  input  logic              m_wready,
  output logic              m_wvalid,
  output logic [ADDR_W-1:0] m_waddr,
  output logic [DATA_W-1:0] m_wdata,
  output logic [NB-1:0]     m_wbe,
  output logic              free
);
  assign free = !m_wvalid || m_wready;

  always_ff @(posedge clk) begin
    if (rst)           m_wvalid <= 1'b0;
    else if (load)     m_wvalid <= 1'b1;
    else if (m_wready) m_wvalid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      m_waddr <= addr;
      m_wdata <= data;
      m_wbe   <= be;
    end
  end
endmodule

// File: rtl/pkt_stream_writer.sv
module pkt_stream_writer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32,
  parameter int ERR_W  = 8,
  localparam int NB      = DATA_W / 8,
  localparam int EMPTY_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int CNT_W   = $clog2(NB + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [ADDR_W-1:0]  desc_addr,
  input  logic [LEN_W-1:0]   desc_len,
  input  logic               desc_end_on_eop,
  input  logic               desc_done_ie,
  input  logic               desc_early_ie,
  input  logic [ERR_W-1:0]   desc_err_mask,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DATA_W-1:0]  s_data,
  input  logic               s_eop,
  input  logic [EMPTY_W-1:0] s_empty,
  input  logic [ERR_W-1:0]   s_err,
  output logic               m_wvalid,
  input  logic               m_wready,
  output logic [ADDR_W-1:0]  m_waddr,
  output logic [DATA_W-1:0]  m_wdata,
  output logic [NB-1:0]      m_wbe,
  output logic               done_valid,
  output logic [LEN_W-1:0]   done_bytes,
  output logic               irq_done,
  output logic               irq_early,
  output logic               irq_err
);
  import pkt_writer_pkg::*;

  wr_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, cnt_q, remaining;
  logic              pkt_mode_q, done_ie_q, early_ie_q, early_q;
  logic [ERR_W-1:0]  mask_q, err_acc;
  logic              wr_free, desc_fire, beat_fire, unlimited, wr_load;
  logic [CNT_W-1:0]  take;
  logic [NB-1:0]     lane_be;
  logic              cap_hit, over;

  assign desc_ready = (state_q == ST_IDLE);
  assign s_ready    = (state_q == ST_RUN && wr_free) || (state_q == ST_DRAIN);
  assign desc_fire  = desc_valid && desc_ready;
  assign beat_fire  = s_valid && s_ready;
  assign unlimited  = &len_q;
  assign remaining  = len_q - cnt_q;
  assign wr_load    = beat_fire && (state_q == ST_RUN) && (take != '0);

  pkt_lane_calc #(
    .NB(NB), .LEN_W(LEN_W), .EMPTY_W(EMPTY_W), .CNT_W(CNT_W)
  ) u_lanes (
    .eop(s_eop), .empty(s_empty), .remaining(remaining), .unlimited(unlimited),
    .take(take), .be(lane_be), .cap_hit(cap_hit), .over(over)
  );

  pkt_err_accum #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .clear(desc_fire), .en(beat_fire),
    .err_in(s_err), .acc(err_acc)
  );

  pkt_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB)) u_wr (
    .clk(clk), .rst(rst), .load(wr_load), .addr(addr_q), .data(s_data),
    .be(lane_be), .m_wready(m_wready), .m_wvalid(m_wvalid),
    .m_waddr(m_waddr), .m_wdata(m_wdata), .m_wbe(m_wbe), .free(wr_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      pkt_mode_q <= 1'b0;
      done_ie_q  <= 1'b0;
      early_ie_q <= 1'b0;
      early_q    <= 1'b0;
      mask_q     <= '0;
      done_valid <= 1'b0;
      done_bytes <= '0;
      irq_done   <= 1'b0;
      irq_early  <= 1'b0;
      irq_err    <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      irq_done   <= 1'b0;
      irq_early  <= 1'b0;
      irq_err    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (desc_fire) begin
            addr_q     <= desc_addr;
            len_q      <= desc_len;
            cnt_q      <= '0;
            pkt_mode_q <= desc_end_on_eop;
            done_ie_q  <= desc_done_ie;
            early_ie_q <= desc_early_ie;
            mask_q     <= desc_err_mask;
            early_q    <= 1'b0;
            state_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (beat_fire) begin
            cnt_q <= cnt_q + LEN_W'(take);
            if (take != '0) addr_q <= addr_q + ADDR_W'(NB);
            if (pkt_mode_q) begin
              if (s_eop && !over) begin
                state_q <= ST_FIN;
              end else if (cap_hit) begin
                early_q <= 1'b1;
                state_q <= s_eop ? ST_FIN : ST_DRAIN;
              end
            end else if (cap_hit) begin
              state_q <= ST_FIN;
            end
          end
        end
        ST_DRAIN: begin
          if (beat_fire && s_eop) state_q <= ST_FIN;
        end
        ST_FIN: begin
          if (wr_free) begin
            done_valid <= 1'b1;
            done_bytes <= cnt_q;
            irq_done   <= done_ie_q;
            irq_early  <= early_q && early_ie_q;
            irq_err    <= |(err_acc & mask_q);
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_stream_writer_chk.sv
module pkt_stream_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32,
  localparam int NB = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_ready,
  input logic              s_ready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic [ADDR_W-1:0] m_waddr,
  input logic [DATA_W-1:0] m_wdata,
  input logic [NB-1:0]     m_wbe,
  input logic              done_valid,
  input logic              irq_done,
  input logic              irq_early,
  input logic              irq_err,
  input logic [LEN_W-1:0]  cnt_q,
  input logic [LEN_W-1:0]  len_q
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_waddr) && $stable(m_wdata) && $stable(m_wbe));

  assert_be_shape_R4: assert property (@(posedge clk) disable iff (rst)
    m_wvalid |-> (m_wbe != '0) && ((m_wbe & (m_wbe + 1'b1)) == '0));

  assert_cap_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len_q);

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    desc_ready |-> !s_ready && !m_wvalid);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_done || irq_early || irq_err) |-> done_valid);

  assert_drained_R10: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> !m_wvalid);
endmodule

bind pkt_stream_writer pkt_stream_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .desc_ready(desc_ready), .s_ready(s_ready),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_waddr(m_waddr),
  .m_wdata(m_wdata), .m_wbe(m_wbe), .done_valid(done_valid),
  .irq_done(irq_done), .irq_early(irq_early), .irq_err(irq_err),
  .cnt_q(cnt_q), .len_q(len_q)
);

// File: tb/tb_pkt_stream_writer.sv
module tb_pkt_stream_writer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 32;
  localparam int ERR_W  = 8;
  localparam int NB      = DATA_W / 8;
  localparam int EMPTY_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int MAXB    = 64;

  logic clk, rst;
  logic desc_valid, desc_ready, desc_end_on_eop, desc_done_ie, desc_early_ie;
  logic [ADDR_W-1:0] desc_addr;
  logic [LEN_W-1:0]  desc_len;
  logic [ERR_W-1:0]  desc_err_mask;
  logic s_valid, s_ready, s_eop;
  logic [DATA_W-1:0] s_data;
  logic [EMPTY_W-1:0] s_empty;
  logic [ERR_W-1:0] s_err;
  logic m_wvalid, m_wready;
  logic [ADDR_W-1:0] m_waddr;
  logic [DATA_W-1:0] m_wdata;
  logic [NB-1:0] m_wbe;
  logic done_valid, irq_done, irq_early, irq_err;
  logic [LEN_W-1:0] done_bytes;

  pkt_stream_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_len(desc_len), .desc_end_on_eop(desc_end_on_eop),
    .desc_done_ie(desc_done_ie), .desc_early_ie(desc_early_ie), .desc_err_mask(desc_err_mask),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_eop(s_eop),
    .s_empty(s_empty), .s_err(s_err), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_waddr(m_waddr), .m_wdata(m_wdata), .m_wbe(m_wbe), .done_valid(done_valid),
    .done_bytes(done_bytes), .irq_done(irq_done), .irq_early(irq_early), .irq_err(irq_err)
  );

  int checks = 0;
  int errors = 0;

  // Prepared beats for the next descriptor
  logic [DATA_W-1:0] b_data [MAXB];
  bit                b_eop  [MAXB];
  int                b_empty[MAXB];
  logic [ERR_W-1:0]  b_err  [MAXB];
  bit                b_drain[MAXB];
  int                nb;

  logic [ADDR_W-1:0] ea[$], ga[$];
  logic [DATA_W-1:0] ed[$], gd[$];
  logic [NB-1:0]     ebe[$], gbe[$];

  bit rdy_rand;
  bit done_seen;
  logic [LEN_W-1:0] got_bytes;
  bit g_done, g_early, g_err;
  longint unsigned last_bytes;
  bit last_early;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Write-port responder and output monitor
  initial begin
    m_wready = 1'b0;
    forever begin
      @(negedge clk);
      m_wready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (!rst && m_wvalid && m_wready) begin
        ga.push_back(m_waddr);
        gd.push_back(m_wdata);
        gbe.push_back(m_wbe);
      end
      if (!rst && done_valid) begin
        done_seen = 1'b1;
        got_bytes = done_bytes;
        g_done    = irq_done;
        g_early   = irq_early;
        g_err     = irq_err;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [DATA_W-1:0] lane_mask(input logic [NB-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < NB; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  function automatic logic [ERR_W-1:0] rand_err();
    return ($urandom % 6 == 0) ? ERR_W'(1 << ($urandom % ERR_W)) : '0;
  endfunction

  task automatic add_beat(input bit eop, input int empty, input logic [ERR_W-1:0] err);
    b_data[nb]  = $urandom;
    b_eop[nb]   = eop;
    b_empty[nb] = empty;
    b_err[nb]   = err;
    nb++;
  endtask

  task automatic add_pkt(input int beats, input int last_empty, input bit with_err);
    for (int i = 0; i < beats; i++)
      add_beat(i == beats - 1, (i == beats - 1) ? last_empty : 0, with_err ? rand_err() : '0);
  endtask

  // Reference model, descriptor issue, beat driving and result comparison
  task automatic run_case(input string tag, input logic [ADDR_W-1:0] base,
                          input logic [LEN_W-1:0] len, input bit pkt_mode,
                          input bit done_ie, input bit early_ie, input logic [ERR_W-1:0] mask);
    longint unsigned cnt, rem, take, bytes;
    bit unl, drain, early, fin;
    int used, k, t;
    logic [ERR_W-1:0] errs;
    cnt = 0; drain = 0; early = 0; fin = 0; used = 0; k = 0; errs = '0;
    unl = (len == '1);
    ea.delete(); ed.delete(); ebe.delete();
    ga.delete(); gd.delete(); gbe.delete();
    for (int i = 0; i < nb && !fin; i++) begin
      used = i + 1;
      b_drain[i] = drain;
      errs |= b_err[i];
      if (drain) begin
        if (b_eop[i]) fin = 1;
      end else begin
        bytes = b_eop[i] ? NB - b_empty[i] : NB;
        rem   = longint'(len) - cnt;
        take  = (unl || bytes <= rem) ? bytes : rem;
        if (take > 0) begin
          ea.push_back(base + ADDR_W'(k * NB));
          ed.push_back(b_data[i]);
          ebe.push_back(NB'((1 << take) - 1));
          k++;
        end
        cnt += take;
        if (pkt_mode) begin
          if (b_eop[i] && (unl || bytes <= rem)) fin = 1;
          else if (!unl && cnt == longint'(len)) begin
            early = 1;
            if (b_eop[i]) fin = 1; else drain = 1;
          end
        end else if (!unl && cnt == longint'(len)) fin = 1;
      end
    end
    last_bytes = cnt;
    last_early = early;

    done_seen = 1'b0;
    @(negedge clk); #2;
    while (!desc_ready) begin @(negedge clk); #2; end
    desc_valid = 1'b1; desc_addr = base; desc_len = len; desc_end_on_eop = pkt_mode;
    desc_done_ie = done_ie; desc_early_ie = early_ie; desc_err_mask = mask;
    @(posedge clk); #1;
    desc_valid = 1'b0;

    for (int i = 0; i < used; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = b_data[i]; s_eop = b_eop[i];
      s_empty = EMPTY_W'(b_empty[i]); s_err = b_err[i];
      #2;
      if (b_drain[i]) chk(s_ready, "R7", {tag, " discard beat not taken at once"}, s_ready, 1);
      while (!s_ready) begin @(negedge clk); #2; end
      @(posedge clk); #1;
      s_valid = 1'b0;
      if (i == 0) chk(!desc_ready, "R2", {tag, " desc_ready during transfer"}, desc_ready, 0);
    end

    t = 0;
    while (!done_seen && t < 3000) begin @(negedge clk); #2; t++; end
    chk(done_seen, "R10", {tag, " done pulse"}, done_seen, 1);
    chk(ga.size() == ea.size(), "R3", {tag, " write count"}, ga.size(), ea.size());
    for (int i = 0; i < ea.size() && i < ga.size(); i++) begin
      chk(ga[i] == ea[i], "R3", {tag, " write address"}, ga[i], ea[i]);
      chk(gbe[i] == ebe[i], "R4", {tag, " byte enables"}, gbe[i], ebe[i]);
      chk((gd[i] & lane_mask(ebe[i])) == (ed[i] & lane_mask(ebe[i])), "R3",
          {tag, " write data"}, gd[i] & lane_mask(ebe[i]), ed[i] & lane_mask(ebe[i]));
    end
    chk(longint'(got_bytes) == cnt, "R5", {tag, " bytes written"}, got_bytes, cnt);
    chk(g_done == done_ie, "R10", {tag, " irq_done"}, g_done, done_ie);
    chk(g_early == (early && early_ie), "R7", {tag, " irq_early"}, g_early, early && early_ie);
    chk(g_err == (|(errs & mask)), "R9", {tag, " irq_err"}, g_err, |(errs & mask));
    nb = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rdy_rand = 1'b1;
    nb = 0;
    rst = 1'b1;
    desc_valid = 0; desc_addr = '0; desc_len = '0; desc_end_on_eop = 0;
    desc_done_ie = 0; desc_early_ie = 0; desc_err_mask = '0;
    s_valid = 0; s_data = '0; s_eop = 0; s_empty = '0; s_err = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(desc_ready && !s_ready && !m_wvalid && !done_valid && !irq_done && !irq_early && !irq_err,
        "R1", "reset state", {desc_ready, s_ready, m_wvalid, done_valid, irq_done, irq_early, irq_err},
        7'b1000000);
    rst = 1'b0;

    // R6: end-of-packet beat fills the limit exactly -> normal end
    add_pkt(3, 1, 0);
    run_case("exact", 32'h1000, 11, 1, 1, 1, 8'hFF);
    chk(last_bytes == 11 && !g_early, "R6", "exact fill no early", {g_early, got_bytes}, 11);

    // R4/R7: end-of-packet beat larger than what remains -> clipped, early
    add_pkt(3, 1, 0);
    run_case("clip", 32'h2000, 10, 1, 1, 1, 8'hFF);

    // R7/R9: limit mid-packet, error on a discarded beat is still counted
    for (int i = 0; i < 6; i++) add_beat(i == 5, 0, (i == 4) ? 8'h10 : 8'h00);
    run_case("drain", 32'h3000, 8, 1, 1, 1, 8'h10);

    // R9: error outside the mask -> no error interrupt
    add_beat(0, 0, 8'h80); add_beat(1, 2, 8'h00);
    run_case("unmasked", 32'h4000, 100, 1, 1, 1, 8'h01);
    // R2: next descriptor starts with cleared errors
    add_pkt(2, 0, 0);
    run_case("cleared", 32'h4100, 100, 1, 1, 1, 8'hFF);
    chk(!g_err, "R2", "errors cleared on new descriptor", g_err, 0);

    // R8: all-ones limit means no cap
    add_pkt(12, 3, 0);
    run_case("unlimited", 32'h5000, '1, 1, 1, 1, 8'hFF);
    chk(got_bytes == 45, "R8", "unlimited bytes", got_bytes, 45);

    // R5: packet flag clear, end-of-packet ignored, empty still honoured
    add_pkt(2, 2, 0); add_pkt(2, 2, 0);
    run_case("noeop", 32'h6000, 10, 0, 1, 1, 8'hFF);

    // R10: interrupt enables off
    add_pkt(4, 0, 1);
    run_case("quiet", 32'h7000, 5, 1, 0, 0, 8'h00);

    // Constrained random transfers
    for (int n = 0; n < 40; n++) begin
      bit pm;
      logic [LEN_W-1:0] ln;
      pm = ($urandom % 3 != 0);
      if (pm) begin
        ln = ($urandom % 3 == 0) ? '1 : LEN_W'(1 + $urandom % 30);
        add_pkt(1 + $urandom % 8, $urandom % NB, 1);
      end else begin
        int tot;
        ln = LEN_W'(1 + $urandom % 40);
        tot = 0;
        while (tot < int'(ln)) begin
          int bt, em;
          bt = 1 + $urandom % 4;
          em = $urandom % NB;
          add_pkt(bt, em, 1);
          tot += bt * NB - em;
        end
      end
      rdy_rand = ($urandom % 5 != 0);
      run_case("random", ($urandom & 32'hFFFF_FFFC), ln, pm, $urandom % 2, $urandom % 2,
               ERR_W'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule